// File: doc/BRIEF.md
# Videophone Call Sequencer

This block is the call-level controller of a videophone. It watches a ring detector, the user's off-hook response, a hang-up request, a send-picture button and a flag that signals an arriving picture. From these it decides whether the audio/video path goes to the live phone path or to the answering recorder, when the camera takes one picture, and when received pictures go to the video unit for processing, display and storage. Codec, modem, multiplexer, compression, camera and display sit outside. They appear here only as start pulses, enables and done inputs.

A call starts with a ring. If the user goes off hook while the line is ringing, the call becomes live. If the number of rings reaches a programmable limit first, the answering recorder takes the call. During a live call the user can send pictures. Pictures can arrive both in a live call and while the recorder runs. A hang-up from any active state drops every enable at once and returns the controller to idle.

Top module: `vp_call_ctrl`

## Requirements
- R1: After reset, and after a reset taken in mid-call, the controller is idle and phone_en, record_en, tx_img_en, rx_img_en and cam_start are all low.
- R2: In idle, only a rising edge on ring_det starts a call, and every enable stays low while ringing. Off-hook and picture inputs in idle have no effect.
- R3: When off_hook is high while ringing, phone_en goes high at the next clock and stays high until hang-up.
- R4: Each rising edge of ring_det is one ring, and the ring that leaves idle counts as the first. When the ring count reaches ring_limit without an off-hook, record_en goes high one clock later. A ring_limit of 0 selects the default of 4 rings.
- R5: phone_en and record_en are never high together.
- R6: send_img_btn is passed through a two-stage synchronizer and edge-detected. In a live call, a rising edge with no picture transfer busy gives exactly one single-cycle cam_start pulse. On that same edge tx_img_en rises, and it stays high until img_out_done. The button is ignored while the recorder runs and while an outgoing transfer is already busy.
- R7: img_in_flag is synchronized and edge-detected in the same way. A rising edge during a live call or while the recorder runs sets rx_img_en until img_in_done.
- R8: When an outgoing request meets an incoming picture, either in the same cycle or while rx_img_en is high, the incoming picture goes first. The outgoing capture waits and starts by itself once img_in_done has cleared rx_img_en.
- R9: A hang_up seen in any non-idle state forces every enable low at the next clock and discards a waiting capture. The controller is back in idle one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_det | input | 1 | Ring detector level; each rising edge is one ring |
| off_hook | input | 1 | User answers the call |
| hang_up | input | 1 | End the call |
| send_img_btn | input | 1 | Send-picture button, asynchronous |
| img_in_flag | input | 1 | Incoming picture present, asynchronous |
| img_in_done | input | 1 | Video unit finished the incoming picture |
| img_out_done | input | 1 | Outgoing picture processed and sent |
| ring_limit | input | RING_CNT_W | Rings before the recorder answers (0 selects default) |
| phone_en | output | 1 | Live phone path enabled |
| record_en | output | 1 | Answering recorder path enabled |
| cam_start | output | 1 | Single-cycle camera capture start |
| tx_img_en | output | 1 | Outgoing picture processing/transmission active |
| rx_img_en | output | 1 | Incoming picture routed to processing, display and storage |

## Verification
The hardest condition to reach is a capture waiting behind an incoming picture. The button edge must reach the arbiter while a receive transfer is busy, or in exactly the cycle the incoming edge arrives. Both inputs pass through synchronizers of the same depth, so the bench drives them on the same falling edge to make their pulses meet. To get the other case, it presses the button while the flag is held high. A separate run hangs up while a capture waits, then places a new call. In that call, img_in_done must not release the old request.

// File: rtl/vp_call_pkg.sv
// Shared types for the videophone call sequencer.
package vp_call_pkg;
    // Call-level states; picture sub-modes live in the arbiter.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RING   = 3'd1,
        ST_TALK   = 3'd2,
        ST_AMACH  = 3'd3,
        ST_HANGUP = 3'd4
    } call_st_e;
endpackage

// File: rtl/vp_edge_pulse.sv
// Optional synchronizer chain followed by a rising-edge detector.
// Assumes: din may be asynchronous when STAGES >= 2; with STAGES == 0
// the pulse is combinational from din and din must be synchronous.
module vp_edge_pulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic [STAGES:0] chain;
    logic            prev;

    assign chain[0] = din;

    // Synchronizer stages, one flop each.
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g+1] <= 1'b0;
            else        chain[g+1] <= chain[g];
        end
    end

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES];
    end

    assign pulse = chain[STAGES] & ~prev;
endmodule

// File: rtl/vp_ring_timer.sv
// Counts ring edges while enabled and flags when the limit is reached.
// Assumes: limit of zero means "use DEF_RINGS"; the count saturates.
module vp_ring_timer #(
    parameter int CNT_W     = 4,
    parameter int DEF_RINGS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             ring_pulse,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] DEF_LIM = CNT_W'(DEF_RINGS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] eff_lim;

    // Select the effective limit.
    always_comb eff_lim = (limit == '0) ? DEF_LIM : limit;

    // Saturating ring counter, cleared whenever counting is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en)             cnt <= '0;
        else if (ring_pulse && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= eff_lim);
endmodule

// File: rtl/vp_image_arb.sv
// Picture sub-modes of a call: outgoing capture/transmit and incoming receive.
// Incoming wins a conflict; a blocked capture waits until receive finishes.
// Assumes: kill is high whenever the call is not live or recording.
module vp_image_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic talk,
    input  logic amach,
    input  logic kill,
    input  logic out_pulse,
    input  logic in_pulse,
    input  logic in_done,
    input  logic out_done,
    output logic out_active,
    output logic in_active,
    output logic cam_start
);
    logic pend;
    logic start_in;
    logic start_out;
    logic block_out;

    // Decide starts for this cycle.
    always_comb begin
        start_in  = (talk | amach) & ~kill & in_pulse & ~in_active;
        start_out = talk & ~kill & (out_pulse | pend) & ~out_active
                  & ~in_active & ~in_pulse;
        block_out = talk & ~kill & out_pulse & ~out_active
                  & (in_active | in_pulse);
    end

    // Sub-mode flags, pending capture and the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            in_active  <= 1'b0;
            out_active <= 1'b0;
            pend       <= 1'b0;
            cam_start  <= 1'b0;
        end else begin
            if (start_in)      in_active <= 1'b1;
            else if (in_done)  in_active <= 1'b0;
            if (start_out)     out_active <= 1'b1;
            else if (out_done) out_active <= 1'b0;
            if (start_out)      pend <= 1'b0;
            else if (block_out) pend <= 1'b1;
            cam_start <= start_out;
        end
    end
endmodule

// File: rtl/vp_call_ctrl.sv
// Top of the videophone call sequencer: call FSM plus ring timer,
// input edge detectors and the picture arbiter.
// Assumes: ring_det, off_hook, hang_up and the done inputs are synchronous;
// send_img_btn and img_in_flag may be asynchronous.
module vp_call_ctrl #(
    parameter int RING_CNT_W = 4,
    parameter int DEF_RINGS  = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ring_det,
    input  logic                  off_hook,
    input  logic                  hang_up,
    input  logic                  send_img_btn,
    input  logic                  img_in_flag,
    input  logic                  img_in_done,
    input  logic                  img_out_done,
    input  logic [RING_CNT_W-1:0] ring_limit,
    output logic                  phone_en,
    output logic                  record_en,
    output logic                  cam_start,
    output logic                  tx_img_en,
    output logic                  rx_img_en
);
    import vp_call_pkg::*;

    call_st_e st, st_nxt;
    logic     ring_pulse, btn_pulse, in_pulse;
    logic     ring_exp;
    logic     talk, amach, kill;

    vp_edge_pulse #(.STAGES(0)) u_ring_edge (
        .clk(clk), .rst_n(rst_n), .din(ring_det), .pulse(ring_pulse)
    );

    vp_edge_pulse #(.STAGES(SYNC_STG)) u_btn_edge (
        .clk(clk), .rst_n(rst_n), .din(send_img_btn), .pulse(btn_pulse)
    );

    vp_edge_pulse #(.STAGES(SYNC_STG)) u_in_edge (
        .clk(clk), .rst_n(rst_n), .din(img_in_flag), .pulse(in_pulse)
    );

    vp_ring_timer #(.CNT_W(RING_CNT_W), .DEF_RINGS(DEF_RINGS)) u_ring_tmr (
        .clk(clk), .rst_n(rst_n),
        .count_en(st == ST_IDLE || st == ST_RING),
        .ring_pulse(ring_pulse), .limit(ring_limit), .expired(ring_exp)
    );

    // Call-level next-state decision; hang-up outranks everything.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (ring_pulse) st_nxt = ST_RING;
            ST_RING: begin
                if (hang_up)       st_nxt = ST_HANGUP;
                else if (off_hook) st_nxt = ST_TALK;
                else if (ring_exp) st_nxt = ST_AMACH;
            end
            ST_TALK,
            ST_AMACH:  if (hang_up) st_nxt = ST_HANGUP;
            ST_HANGUP: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Picture sub-modes only exist in a live or recorded call.
    always_comb begin
        talk  = (st == ST_TALK);
        amach = (st == ST_AMACH);
        kill  = hang_up | ~(talk | amach);
    end

    vp_image_arb u_img_arb (
        .clk(clk), .rst_n(rst_n), .talk(talk), .amach(amach), .kill(kill),
        .out_pulse(btn_pulse), .in_pulse(in_pulse),
        .in_done(img_in_done), .out_done(img_out_done),
        .out_active(tx_img_en), .in_active(rx_img_en), .cam_start(cam_start)
    );

    assign phone_en  = talk;
    assign record_en = amach;
endmodule

// File: rtl/vp_call_ctrl_chk.sv
// Temporal checks on the call sequencer ports, bound into the top.
module vp_call_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hang_up,
    input logic phone_en,
    input logic record_en,
    input logic cam_start,
    input logic tx_img_en,
    input logic rx_img_en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !(phone_en || record_en || cam_start || tx_img_en || rx_img_en));

    // R5
    path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phone_en && record_en));

    // R6
    cam_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cam_start |=> !cam_start);

    // R6
    cam_in_talk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cam_start |-> (phone_en && tx_img_en));

    // R6
    rec_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        record_en |-> !tx_img_en);

    // R9
    hangup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hang_up && (phone_en || record_en)) |=>
        !(phone_en || record_en || cam_start || tx_img_en || rx_img_en));
endmodule

bind vp_call_ctrl vp_call_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hang_up(hang_up),
    .phone_en(phone_en), .record_en(record_en), .cam_start(cam_start),
    .tx_img_en(tx_img_en), .rx_img_en(rx_img_en)
);

// File: tb/vp_call_ctrl_tb.sv
module vp_call_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_det = 0, off_hook = 0, hang_up = 0;
    logic       send_img_btn = 0, img_in_flag = 0, img_in_done = 0, img_out_done = 0;
    logic [3:0] ring_limit = 4'd0;
    logic       phone_en, record_en, cam_start, tx_img_en, rx_img_en;

    int errors = 0;
    int checks = 0;
    int cam_cnt = 0;

    always #10 clk = ~clk;

    vp_call_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ring_det(ring_det), .off_hook(off_hook),
        .hang_up(hang_up), .send_img_btn(send_img_btn), .img_in_flag(img_in_flag),
        .img_in_done(img_in_done), .img_out_done(img_out_done),
        .ring_limit(ring_limit), .phone_en(phone_en), .record_en(record_en),
        .cam_start(cam_start), .tx_img_en(tx_img_en), .rx_img_en(rx_img_en)
    );

    // Count capture strobes; a two-cycle strobe would count twice.
    always @(posedge clk) if (cam_start) cam_cnt++;

    // Vector: inputs {ring,offh,hang,btn,iflag,idone,odone}, edges to hold,
    // expected {phone,rec,tx,rx}, expected capture count (low 4 bits).
    localparam int NV = 23;
    localparam logic [17:0] VEC [NV] = '{
        18'b0000000_010_0000_0000, // R2 idle quiet
        18'b1000000_010_0000_0000, // R2 ringing, enables low
        18'b0000000_010_0000_0000,
        18'b0100000_011_1000_0000, // R3 answered
        18'b0001000_100_1010_0001, // R6 capture
        18'b0000001_010_1000_0001, // R6 out done
        18'b0000100_100_1001_0001, // R7 incoming
        18'b0001100_100_1001_0001, // R8 press during receive waits
        18'b0000010_100_1010_0010, // R8 waiting capture launches
        18'b0000001_010_1000_0010,
        18'b0010000_001_0000_0010, // R9 hang-up clears
        18'b0000000_010_0000_0010, // R9 back to idle
        18'b1000000_010_0000_0010, // R4 ring 1
        18'b0000000_010_0000_0010,
        18'b1000000_010_0000_0010, // R4 ring 2
        18'b0000000_010_0000_0010,
        18'b1000000_010_0000_0010, // R4 ring 3
        18'b0000000_010_0000_0010,
        18'b1000000_011_0100_0010, // R4 ring 4 -> recorder
        18'b0001000_100_0100_0010, // R6 button ignored in recorder
        18'b0000100_100_0101_0010, // R7 incoming while recording
        18'b0010000_001_0000_0010, // R9 hang-up from recorder
        18'b0000000_010_0000_0010
    };

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(logic [6:0] v, int hold);
        {ring_det, off_hook, hang_up, send_img_btn, img_in_flag, img_in_done, img_out_done} = v;
        repeat (hold) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(string req, logic [3:0] e, logic [3:0] cam_e);
        chk(req, {4'h0, phone_en, record_en, tx_img_en, rx_img_en}, {4'h0, e});
        chk(req, {4'h0, 4'(cam_cnt)}, {4'h0, cam_e});
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", {3'b0, phone_en, record_en, tx_img_en, rx_img_en, cam_start}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:11], int'(VEC[i][10:8]));
            expect_out($sformatf("vec%0d", i), VEC[i][7:4], VEC[i][3:0]);
        end

        // R8: button and incoming picture arrive in the same cycle
        apply(7'b1000000, 2);
        apply(7'b0100000, 3);
        apply(7'b0001100, 4);
        expect_out("R8 same-cycle incoming wins", 4'b1001, 4'd2);
        apply(7'b0000010, 4);
        expect_out("R8 capture after receive", 4'b1010, 4'd3);
        apply(7'b0000001, 2);
        expect_out("R6 out done", 4'b1000, 4'd3);

        // R9: hang-up discards a waiting capture
        apply(7'b0000100, 4);
        apply(7'b0001100, 4);
        expect_out("R9 capture waiting", 4'b1001, 4'd3);
        apply(7'b0010000, 1);
        expect_out("R9 hang-up all low", 4'b0000, 4'd3);
        apply(7'b0000000, 2);
        apply(7'b1000000, 2);
        apply(7'b0100000, 3);
        apply(7'b0000010, 4);
        expect_out("R9 no stale capture", 4'b1000, 4'd3);
        apply(7'b0010000, 1);
        apply(7'b0000000, 2);

        // R4: programmed limit of two rings
        ring_limit = 4'd2;
        apply(7'b1000000, 2);
        apply(7'b0000000, 2);
        expect_out("R4 one ring of two", 4'b0000, 4'd3);
        apply(7'b1000000, 3);
        expect_out("R4 recorder after two", 4'b0100, 4'd3);
        apply(7'b0010000, 1);
        apply(7'b0000000, 2);
        ring_limit = 4'd0;

        // R9 hang-up while ringing, then R2 off-hook in idle ignored
        apply(7'b1000000, 2);
        apply(7'b0010000, 1);
        expect_out("R9 hang-up in ring", 4'b0000, 4'd3);
        apply(7'b0000000, 2);
        apply(7'b0100100, 4);
        expect_out("R2 idle ignores off-hook", 4'b0000, 4'd3);
        apply(7'b0000000, 2);

        // R1: reset in mid-call
        apply(7'b1000000, 2);
        apply(7'b0100000, 3);
        apply(7'b0000100, 4);
        expect_out("R7 before reset", 4'b1001, 4'd3);
        rst_n = 1'b0;
        apply(7'b0000000, 2);
        expect_out("R1 mid-call reset", 4'b0000, 4'd3);
        rst_n = 1'b1;
        apply(7'b0100000, 3);
        expect_out("R1 idle after reset", 4'b0000, 4'd3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule